// File: doc/BRIEF.md
# Descending Memory-to-Port Byte Sequencer

This block moves a run of bytes from memory to a single fixed I/O port. A start pulse loads a byte count, a memory source address, a 16-bit port address, a pointer-width mode bit, a setup-override bit and an incoming flag byte. For every byte the block reads memory at the source pointer, then writes that byte to the port address. After the write it steps the pointer down by one and the count down by one. The port address does not move during the transfer.

The loop ends when the count reaches zero. The block then pulses `done` and drops `busy`. The remaining count, the current pointer, the flag byte and the number of busy cycles stay visible on outputs. Both the memory read and the port write use valid/ready handshakes, so slow memory or a slow peripheral only lengthens the run.

Top module: `desc_port_streamer`

## Requirements
- R1: After reset, `busy`, `done`, `rd_valid`, `wr_valid`, `cyc_o` and `flags_o` are all zero.
- R2: A `start` seen at a clock edge while idle loads all inputs. `busy` is high from the next cycle until the last byte is done. `done` is a single-cycle pulse in the first cycle after `busy` falls.
- R3: A `start` that arrives while `busy` is high is ignored. The running transfer keeps its count, pointer and port address.
- R4: Each byte is first read from memory at the current pointer and then written, unchanged, to the port. Successive reads use strictly descending addresses.
- R5: During the whole transfer, the low 16 bits of `wr_addr` equal the port address loaded at start. The bits above them are unspecified.
- R6: After each byte, the count and the pointer each drop by one. The transfer ends once the count reaches zero. A start count of zero moves 2^CNT_W bytes.
- R7: With `long_i`=1 the pointer decrements across all ADDR_W bits. With `long_i`=0 only the low 16 bits decrement and wrap, and the bits above them keep their value.
- R8: After each byte, flag bit 6 (zero) is set if the count became zero and cleared otherwise. It is therefore always set at completion.
- R9: After each byte, flag bit 1 takes bit 7 of that byte. All other flag bits keep the values loaded from `flags_i`.
- R10: With `rd_ready` and `wr_ready` held high, `cyc_o` ends at 2 + 3×N busy cycles, or 3 + 3×N when `ovr_i`=1, where N is the number of bytes.
- R11: Once raised, `rd_valid`/`rd_addr` and `wr_valid`/`wr_addr`/`wr_data` hold steady until the matching ready is seen. Stalls change only the timing, never the data moved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| count_i | input | CNT_W | Byte count, 0 means 2^CNT_W |
| src_i | input | ADDR_W | Highest memory address to read |
| port_i | input | PORT_W | Port address |
| long_i | input | 1 | 1: full-width pointer, 0: 16-bit pointer |
| ovr_i | input | 1 | 1: one extra setup cycle |
| flags_i | input | 8 | Flag byte loaded at start |
| rd_valid | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Memory read address |
| rd_ready | input | 1 | Memory read accepted, data valid |
| rd_data | input | 8 | Memory read data |
| wr_valid | output | 1 | Port write request |
| wr_addr | output | ADDR_W | Port write address |
| wr_data | output | 8 | Port write data |
| wr_ready | input | 1 | Port write accepted |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| cnt_o | output | CNT_W | Remaining byte count |
| ptr_o | output | ADDR_W | Current source pointer |
| flags_o | output | 8 | Flag byte |
| cyc_o | output | CNT_W+2 | Busy cycles of the latest transfer |

## Verification
The bench builds the block with CNT_W=6 and keeps the default 24-bit address and 16-bit port width. With a 6-bit count, the zero-count case (64 bytes) runs in about two hundred cycles. The full-width wrap of the pointer below address zero can then be checked in the same run as the 16-bit wrap that leaves the upper byte untouched. The narrow count also keeps the cycle counter small enough that both setup lengths are checked exactly.

// File: rtl/dps_pkg.sv
package dps_pkg;
   localparam int FLAG_W = 8;
   localparam int FL_Z   = 6;
   localparam int FL_N   = 1;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SETUP = 3'd1,
      ST_RD    = 3'd2,
      ST_WR    = 3'd3,
      ST_UPD   = 3'd4
   } st_e;
endpackage

// File: rtl/dps_ptr_step.sv
module dps_ptr_step #(
   parameter int ADDR_W  = 24,
   parameter int SHORT_W = 16
) (
   input  logic [ADDR_W-1:0] cur,
   input  logic              long_mode,
   output logic [ADDR_W-1:0] nxt
);
   localparam logic [ADDR_W-1:0]  ONE_F = 1;
   localparam logic [SHORT_W-1:0] ONE_S = 1;

   generate
      if (ADDR_W > SHORT_W) begin : g_split
         logic [ADDR_W-1:0]  full_dec;
         logic [SHORT_W-1:0] low_dec;
         always_comb begin
            full_dec = cur - ONE_F;
            low_dec  = cur[SHORT_W-1:0] - ONE_S;
            nxt      = long_mode ? full_dec : {cur[ADDR_W-1:SHORT_W], low_dec};
         end
      end else begin : g_flat
         logic unused_mode;
         assign unused_mode = long_mode;
         assign nxt = cur - ONE_F;
      end
   endgenerate
endmodule

// File: rtl/dps_flag_upd.sv
module dps_flag_upd
   import dps_pkg::*;
(
   input  logic [FLAG_W-1:0] prev,
   input  logic              byte_msb,
   input  logic              cnt_zero,
   output logic [FLAG_W-1:0] nxt
);
   always_comb begin
      nxt       = prev;
      nxt[FL_Z] = cnt_zero;
      nxt[FL_N] = byte_msb;
   end
endmodule

// File: rtl/dps_cyc_ctr.sv
module dps_cyc_ctr #(
   parameter int W = 18
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] ONE = 1;

   always_ff @(posedge clk) begin
      if (!rst_n)   q <= '0;
      else if (clr) q <= '0;
      else if (inc) q <= q + ONE;
   end
endmodule

// File: rtl/desc_port_streamer.sv
module desc_port_streamer
   import dps_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int SHORT_W = 16,
   parameter int PORT_W  = 16,
   parameter int CNT_W   = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [CNT_W-1:0]       count_i,
   input  logic [ADDR_W-1:0]      src_i,
   input  logic [PORT_W-1:0]      port_i,
   input  logic                   long_i,
   input  logic                   ovr_i,
   input  logic [7:0]             flags_i,
   output logic                   rd_valid,
   output logic [ADDR_W-1:0]      rd_addr,
   input  logic                   rd_ready,
   input  logic [7:0]             rd_data,
   output logic                   wr_valid,
   output logic [ADDR_W-1:0]      wr_addr,
   output logic [7:0]             wr_data,
   input  logic                   wr_ready,
   output logic                   busy,
   output logic                   done,
   output logic [CNT_W-1:0]       cnt_o,
   output logic [ADDR_W-1:0]      ptr_o,
   output logic [7:0]             flags_o,
   output logic [CNT_W+1:0]       cyc_o
);
   localparam int CYC_W = CNT_W + 2;
   localparam logic [CNT_W-1:0] CNT_ONE = 1;
   localparam logic [1:0] SETUP_STD = 2'd1;
   localparam logic [1:0] SETUP_OVR = 2'd2;
   localparam logic [FLAG_W-1:0] KEEP_MASK =
      ~((FLAG_W'(1) << FL_Z) | (FLAG_W'(1) << FL_N));

   initial begin
      assert (ADDR_W >= SHORT_W && ADDR_W >= PORT_W && CNT_W >= 2)
         else $error("desc_port_streamer: bad width parameters");
   end

   st_e                 state_q;
   logic [1:0]          setup_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [ADDR_W-1:0]   ptr_q;
   logic [PORT_W-1:0]   port_q;
   logic                long_q;
   logic [FLAG_W-1:0]   flags_q;
   logic [7:0]          data_q;
   logic                done_q;

   logic [CNT_W-1:0]    cnt_dec;
   logic [ADDR_W-1:0]   ptr_nxt;
   logic [FLAG_W-1:0]   flags_nxt;
   logic                take_start;

   assign cnt_dec    = cnt_q - CNT_ONE;
   assign take_start = (state_q == ST_IDLE) && start;

   dps_ptr_step #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W)) u_ptr (
      .cur       (ptr_q),
      .long_mode (long_q),
      .nxt       (ptr_nxt)
   );

   dps_flag_upd u_flag (
      .prev     (flags_q),
      .byte_msb (data_q[7]),
      .cnt_zero (cnt_dec == '0),
      .nxt      (flags_nxt)
   );

   dps_cyc_ctr #(.W(CYC_W)) u_cyc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (take_start),
      .inc   (state_q != ST_IDLE),
      .q     (cyc_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         setup_q <= '0;
         cnt_q   <= '0;
         ptr_q   <= '0;
         port_q  <= '0;
         long_q  <= 1'b0;
         flags_q <= '0;
         data_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (start) begin
               cnt_q   <= count_i;
               ptr_q   <= src_i;
               port_q  <= port_i;
               long_q  <= long_i;
               flags_q <= flags_i;
               setup_q <= ovr_i ? SETUP_OVR : SETUP_STD;
               state_q <= ST_SETUP;
            end
            ST_SETUP: begin
               if (setup_q == 2'd0) state_q <= ST_RD;
               else                 setup_q <= setup_q - 2'd1;
            end
            ST_RD: if (rd_ready) begin
               data_q  <= rd_data;
               state_q <= ST_WR;
            end
            ST_WR: if (wr_ready) state_q <= ST_UPD;
            ST_UPD: begin
               cnt_q   <= cnt_dec;
               ptr_q   <= ptr_nxt;
               flags_q <= flags_nxt;
               if (cnt_dec == '0) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  state_q <= ST_RD;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   generate
      if (ADDR_W > PORT_W) begin : g_port_pad
         assign wr_addr = {{(ADDR_W-PORT_W){1'b0}}, port_q};
      end else begin : g_port_flat
         assign wr_addr = port_q;
      end
   endgenerate

   assign rd_valid = (state_q == ST_RD);
   assign rd_addr  = ptr_q;
   assign wr_valid = (state_q == ST_WR);
   assign wr_data  = data_q;
   assign busy     = (state_q != ST_IDLE);
   assign done     = done_q;
   assign cnt_o    = cnt_q;
   assign ptr_o    = ptr_q;
   assign flags_o  = flags_q;

   // R11: requests hold until accepted
   p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));
   p_wr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
   // R5: port address fixed during a transfer
   p_port_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> $stable(wr_addr[PORT_W-1:0]));
   // R6: count only ever steps down by one while running
   p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) && !$stable(cnt_o) |-> cnt_o == $past(cnt_o) - CNT_ONE);
   // R8: completion leaves zero count and zero flag
   p_done_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> cnt_o == '0 && flags_o[FL_Z]);
   // R9: untouched flag bits keep their loaded value
   p_flag_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> (flags_o & KEEP_MASK) == ($past(flags_o) & KEEP_MASK));
   // R2: done is a single pulse with busy low
   p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy ##1 !done);

   generate
      if (ADDR_W > SHORT_W) begin : g_chk_short
         // R7: short mode holds the upper pointer bits
         p_short_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
            busy && $past(busy) && !long_q |->
               ptr_o[ADDR_W-1:SHORT_W] == $past(ptr_o[ADDR_W-1:SHORT_W]));
      end
   endgenerate
endmodule

// File: tb/tb_desc_port_streamer.sv
module tb_desc_port_streamer;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 6;
   localparam int AW = 24;
   localparam int WD_LIMIT = 20000;

   typedef struct packed {
      logic        lng;
      logic        ovr;
      logic        stl;
      logic [5:0]  cnt;
      logic [23:0] src;
      logic [15:0] port;
      logic [7:0]  fl;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{1'b1, 1'b0, 1'b0, 6'd5, 24'h120003, 16'hBEEF, 8'h00},
      '{1'b0, 1'b0, 1'b0, 6'd4, 24'h340001, 16'h0042, 8'hFF},
      '{1'b1, 1'b1, 1'b1, 6'd7, 24'h000010, 16'h1234, 8'h95},
      '{1'b0, 1'b1, 1'b0, 6'd1, 24'h7F8000, 16'hFFFF, 8'h2A},
      '{1'b1, 1'b0, 1'b0, 6'd0, 24'h000020, 16'h00C0, 8'h40},
      '{1'b0, 1'b0, 1'b1, 6'd3, 24'hAB0001, 16'h5555, 8'hBD}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [CW-1:0] count_i = '0;
   logic [AW-1:0] src_i = '0;
   logic [15:0]   port_i = '0;
   logic          long_i = 1'b0;
   logic          ovr_i = 1'b0;
   logic [7:0]    flags_i = '0;
   logic          rd_valid, wr_valid, rd_ready, wr_ready, busy, done;
   logic [AW-1:0] rd_addr, wr_addr, ptr_o;
   logic [7:0]    rd_data, wr_data, flags_o;
   logic [CW-1:0] cnt_o;
   logic [CW+1:0] cyc_o;

   logic          stall_en = 1'b0;
   logic [1:0]    tick = '0;
   int            checks = 0, fails = 0, cycles = 0;
   bit            timeout = 0;
   int            rd_n = 0, wr_n = 0, done_n = 0;
   logic [AW-1:0] rd_log [128];
   logic [15:0]   wa_log [128];
   logic [7:0]    wd_log [128];

   function automatic logic [7:0] mem_byte(input logic [23:0] a);
      return a[7:0] ^ {a[12:8], a[15:13]} ^ a[23:16] ^ 8'hA5;
   endfunction

   function automatic logic [23:0] step_down(input logic [23:0] p, input logic lng, input int k);
      logic [23:0] kk;
      kk = 24'(k);
      if (lng) return p - kk;
      return {p[23:16], p[15:0] - kk[15:0]};
   endfunction

   always #(CLK_PERIOD/2) clk = ~clk;

   assign rd_data  = mem_byte(rd_addr);
   assign rd_ready = !stall_en || (tick == 2'b01);
   assign wr_ready = !stall_en || tick[0];

   always_ff @(posedge clk) tick <= tick + 2'd1;

   always @(posedge clk) begin
      cycles++;
      if (cycles > WD_LIMIT) timeout = 1;
      if (rd_valid && rd_ready && rd_n < 128) begin rd_log[rd_n] = rd_addr; rd_n++; end
      if (wr_valid && wr_ready && wr_n < 128) begin
         wa_log[wr_n] = wr_addr[15:0]; wd_log[wr_n] = wr_data; wr_n++;
      end
      if (done) done_n++;
   end

   desc_port_streamer #(.ADDR_W(AW), .SHORT_W(16), .PORT_W(16), .CNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .count_i(count_i), .src_i(src_i),
      .port_i(port_i), .long_i(long_i), .ovr_i(ovr_i), .flags_i(flags_i),
      .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
      .busy(busy), .done(done), .cnt_o(cnt_o), .ptr_o(ptr_o), .flags_o(flags_o),
      .cyc_o(cyc_o)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic launch(input vec_t v);
      @(negedge clk);
      rd_n = 0; wr_n = 0; done_n = 0;
      stall_en = v.stl;
      count_i = v.cnt; src_i = v.src; port_i = v.port;
      long_i = v.lng; ovr_i = v.ovr; flags_i = v.fl;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      while (!done && !timeout) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic verify(input vec_t v, input bit chk_cyc);
      int n, bad_rd, bad_wd, bad_pa, setup;
      logic [7:0] last, exp_fl;
      n = (v.cnt == 0) ? 64 : int'(v.cnt);
      bad_rd = 0; bad_wd = 0; bad_pa = 0;
      for (int i = 0; i < n && i < 128; i++) begin
         if (rd_log[i] !== step_down(v.src, v.lng, i)) bad_rd++;
         if (wd_log[i] !== mem_byte(step_down(v.src, v.lng, i))) bad_wd++;
         if (wa_log[i] !== v.port) bad_pa++;
      end
      last = mem_byte(step_down(v.src, v.lng, n - 1));
      exp_fl = (v.fl & 8'hBD) | 8'h40 | {6'b0, last[7], 1'b0};
      chk(wr_n == n && rd_n == n, "R6 byte count", wr_n, n);
      chk(bad_rd == 0, "R4 read order", bad_rd, 0);
      chk(bad_wd == 0, "R4/R11 written data", bad_wd, 0);
      chk(bad_pa == 0, "R5 port address", bad_pa, 0);
      chk(ptr_o == step_down(v.src, v.lng, n), "R7 final pointer", ptr_o, step_down(v.src, v.lng, n));
      chk(cnt_o == 0, "R6 final count", cnt_o, 0);
      chk(flags_o == exp_fl, "R8/R9 flags", flags_o, exp_fl);
      chk(done_n == 1 && !busy, "R2 done pulse", done_n, 1);
      setup = v.ovr ? 3 : 2;
      if (chk_cyc) begin
         if (!v.stl) chk(int'(cyc_o) == setup + 3*n, "R10 cycle count", cyc_o, setup + 3*n);
         else        chk(int'(cyc_o) > setup + 3*n, "R11 stall lengthens", cyc_o, setup + 3*n);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!busy && !done && !rd_valid && !wr_valid, "R1 idle outputs", {busy, done, rd_valid, wr_valid}, 0);
      chk(cyc_o == 0 && flags_o == 0, "R1 counters", {cyc_o, flags_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      foreach (VECS[k]) begin
         launch(VECS[k]);
         chk(busy, "R2 busy after start", busy, 1);
         wait_done();
         verify(VECS[k], 1'b1);
      end

      // R3: start while busy is ignored
      begin
         vec_t a, b;
         a = '{1'b1, 1'b0, 1'b0, 6'd4, 24'h000100, 16'h0A0A, 8'h00};
         b = '{1'b0, 1'b1, 1'b0, 6'd9, 24'h000500, 16'h7777, 8'hFF};
         launch(a);
         repeat (4) @(negedge clk);
         count_i = b.cnt; src_i = b.src; port_i = b.port; long_i = b.lng; flags_i = b.fl;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         wait_done();
         chk(wr_n == 4, "R3 ignored start count", wr_n, 4);
         verify(a, 1'b0);
      end

      // R8: zero flag cleared mid-transfer, count decremented once
      begin
         vec_t c;
         c = '{1'b1, 1'b0, 1'b0, 6'd3, 24'h000040, 16'h0001, 8'h40};
         launch(c);
         while (!(wr_valid && wr_ready) && !timeout) @(negedge clk);
         @(negedge clk);
         @(negedge clk);
         chk(flags_o[6] == 1'b0, "R8 zero flag clear mid-run", flags_o[6], 0);
         chk(cnt_o == 6'd2, "R6 count after first byte", cnt_o, 2);
         wait_done();
         verify(c, 1'b1);
      end

      if (timeout) begin
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, WD_LIMIT);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule